// File: doc/BRIEF.md
# IPv4 Header Validator and TTL Rewriter

This block sits in the ingress path of a forwarding engine. An IPv4 header reaches it as a stream of 16-bit words. The first word is flagged as start and the last as end. Two side inputs are sampled with the first word:
- the byte count reported by the link layer;
- a flag that is set when the router itself is the destination.

Each word is passed on one cycle later. For a forwarded packet, the word holding the hop limit and the protocol (word index 4) is rewritten, and so is the checksum word (index 5). The new checksum is computed incrementally from the old checksum and the old and new index-4 words, so the header is never summed a second time.

One cycle after the last header word, the block emits exactly one verdict code:
- forward;
- deliver locally;
- hand to the slow path (options present);
- drop and ask for an error report to the sender (hop limit exhausted);
- discard as malformed.

A header that fails validation outranks the options check, and the options check outranks the hop-limit rules.

Top module: `ipv4_hdr_rewrite`

## Requirements
- R1: Every accepted input word appears on `out_word` exactly one cycle later, with its start and end marks. Every word other than index 4 and index 5 is unchanged.
- R2: Exactly one verdict is produced per header, with `dec_valid` high only in the cycle after the end-marked word. The codes are 0 forward, 1 local, 2 slow path, 3 expired (drop with error report), 4 malformed. Out of reset, `out_valid` and `dec_valid` are low.
- R3: A header whose version nibble (word 0, bits 15:12) is not 4 gets code 4.
- R4: A header whose link-layer byte count, sampled with the first word, is below 20 gets code 4.
- R5: A header gets code 4 in any of these cases: its length field (word 0, bits 11:8) is below 5; its total-length word (index 1) is below four times that field; or its word count differs from twice that field.
- R6: The checksum check forms the ones-complement sum, with end-around carry, of all header words except index 5, then complements it. A result that differs from word 5 gives code 4. Example: words 4500 0089 9713 0000 3e11 xxxx 0a03 0001 e000 6464 require 96e8.
- R7: A well-formed header whose length field exceeds 5 gets code 2, whatever its hop limit or destination.
- R8: A well-formed header without options and marked for the router gets code 1 for any hop limit, including 0. Its words 4 and 5 pass unchanged.
- R9: A well-formed header without options and not for the router gets code 0 when its hop limit (word 4, bits 15:8) exceeds 1, and code 3 otherwise.
- R10: When a header is not for the router and its hop limit is non-zero, the rewrite applies; with a hop limit of 0, no word changes. The rewrite works as follows:
  - Word 4 leaves with its high byte lowered by one and its low byte kept.
  - Word 5 leaves as the complement of the end-around sum of the complemented old checksum, the complemented old word 4 and the new word 4.
  - When the received checksum was correct, this equals a full recomputation over the rewritten header, including when the result is 0x0000 and when the old checksum was 0x0000.
- R11: Ranking is malformed before slow path before the hop-limit outcomes. A header with options and a bad checksum gets 4, and a header with options and a hop limit of 1 gets 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Input word is the first of a header |
| in_eop | input | 1 | Input word is the last of a header |
| in_word | input | 16 | Header word |
| in_l2_len | input | 16 | Link-layer byte count, sampled with the first word |
| in_local | input | 1 | Router is the destination, sampled with the first word |
| out_valid | output | 1 | Output word present |
| out_sop | output | 1 | Output word is the first of a header |
| out_eop | output | 1 | Output word is the last of a header |
| out_word | output | 16 | Possibly rewritten header word |
| dec_valid | output | 1 | Verdict present |
| dec_code | output | 3 | Verdict code |

## Verification
The properties assume three things about the input:
- a new header opens with a start-marked word;
- the side inputs are meaningful on that start word;
- an end mark closes each header before the next start.

The checker also keeps its own copy of the version nibble, the byte count and the destination flag from each start word. A verdict is judged against the header that opened most recently. The bench keeps within these assumptions by always driving start and end marks in matched pairs, separated by an idle cycle. It holds the side inputs steady across each header. Its randomised headers inject one fault at a time, or none, over a spread of hop limits and option lengths.

// File: rtl/ipv4_chk_pkg.sv
package ipv4_chk_pkg;

   typedef enum logic [2:0] {
      VERD_FWD    = 3'd0,
      VERD_LOCAL  = 3'd1,
      VERD_SLOW   = 3'd2,
      VERD_EXPIRE = 3'd3,
      VERD_BAD    = 3'd4
   } verdict_e;

   // fields gathered from the header as it streams past
   typedef struct packed {
      logic [3:0]  ver;
      logic [3:0]  ihl;
      logic [15:0] tot_len;
      logic [7:0]  ttl;
      logic [15:0] rx_cks;
      logic [15:0] l2_len;
      logic        local_dst;
   } hdr_fields_t;

   // 16-bit ones-complement add with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

endpackage

// File: rtl/ipv4_csum_acc.sv
module ipv4_csum_acc
   import ipv4_chk_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned SKIP_IDX  = 5,
   parameter bit          FOLD_EACH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             valid,
   input  logic [CNT_W-1:0] idx,
   input  logic [W-1:0]     word,
   output logic [W-1:0]     sum_o
);
   localparam logic [CNT_W-1:0] SKIP = CNT_W'(SKIP_IDX);

   logic [W-1:0] addend;
   assign addend = (idx == SKIP) ? '0 : word;

   generate
      if (FOLD_EACH) begin : g_fold_each
         // carry folded back on every word: 16-bit state, adder chain per cycle
         logic [W-1:0] acc_q, acc_n;
         always_comb begin
            acc_n = oc_add(start ? '0 : acc_q, addend);
         end
         always_ff @(posedge clk) begin
            if (!rst_n)     acc_q <= '0;
            else if (valid) acc_q <= acc_n;
         end
         assign sum_o = acc_n;
      end else begin : g_fold_late
         // wide binary sum, carries folded only when the result is read
         localparam int unsigned ACC_W = W + CNT_W;
         logic [ACC_W-1:0] acc_q, acc_n;
         logic [W:0]       fold1;
         always_comb begin
            acc_n = (start ? '0 : acc_q) + ACC_W'(addend);
            fold1 = {1'b0, acc_n[W-1:0]} + (W+1)'(acc_n[ACC_W-1:W]);
         end
         always_ff @(posedge clk) begin
            if (!rst_n)     acc_q <= '0;
            else if (valid) acc_q <= acc_n;
         end
         assign sum_o = fold1[W-1:0] + {{(W-1){1'b0}}, fold1[W]};
      end
   endgenerate

endmodule

// File: rtl/ipv4_ttl_patch.sv
module ipv4_ttl_patch
   import ipv4_chk_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned TTL_IDX = 4,
   parameter int unsigned CKS_IDX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [CNT_W-1:0] idx,
   input  logic [W-1:0]     word,
   input  logic             fwd,
   output logic [W-1:0]     word_o
);
   localparam logic [CNT_W-1:0] I_TTL = CNT_W'(TTL_IDX);
   localparam logic [CNT_W-1:0] I_CKS = CNT_W'(CKS_IDX);

   logic         hit_ttl;
   logic [W-1:0] dec_word;
   logic         rw_q;
   logic [W-1:0] old_q, new_q;

   assign hit_ttl  = (idx == I_TTL) && fwd && (word[W-1:W-8] != 8'd0);
   assign dec_word = {word[W-1:W-8] - 8'd1, word[W-9:0]};

   always_comb begin
      word_o = word;
      if (hit_ttl)
         word_o = dec_word;
      else if ((idx == I_CKS) && rw_q)
         word_o = ~oc_add(oc_add(~word, ~old_q), new_q);
   end

   // the checksum word directly follows the hop-limit word, so the
   // pending flag needs to survive exactly one accepted word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rw_q  <= 1'b0;
         old_q <= '0;
         new_q <= '0;
      end else if (valid) begin
         rw_q <= hit_ttl;
         if (hit_ttl) begin
            old_q <= word;
            new_q <= dec_word;
         end
      end
   end

endmodule

// File: rtl/ipv4_verdict.sv
module ipv4_verdict
   import ipv4_chk_pkg::*;
#(
   parameter int unsigned W             = 16,
   parameter int unsigned CNT_W         = 5,
   parameter int unsigned MIN_HDR_BYTES = 20
) (
   input  hdr_fields_t      fld,
   input  logic [CNT_W-1:0] cnt,
   input  logic [W-1:0]     sum,
   output verdict_e         code
);
   localparam logic [15:0] MIN_L2   = 16'(MIN_HDR_BYTES);
   localparam logic [3:0]  BASE_IHL = 4'(MIN_HDR_BYTES / 4);

   logic bad_ver, bad_l2, bad_ihl, bad_tot, bad_cnt, bad_cks, malformed;

   always_comb begin
      bad_ver   = (fld.ver != 4'd4);
      bad_l2    = (fld.l2_len < MIN_L2);
      bad_ihl   = (fld.ihl < BASE_IHL);
      bad_tot   = (fld.tot_len < {10'd0, fld.ihl, 2'b00});
      bad_cnt   = (cnt != CNT_W'({fld.ihl, 1'b0}));
      bad_cks   = (~sum != fld.rx_cks);
      malformed = bad_ver | bad_l2 | bad_ihl | bad_tot | bad_cnt | bad_cks;

      if (malformed)                 code = VERD_BAD;
      else if (fld.ihl > BASE_IHL)   code = VERD_SLOW;
      else if (fld.local_dst)        code = VERD_LOCAL;
      else if (fld.ttl <= 8'd1)      code = VERD_EXPIRE;
      else                           code = VERD_FWD;
   end

endmodule

// File: rtl/ipv4_hdr_rewrite.sv
module ipv4_hdr_rewrite
   import ipv4_chk_pkg::*;
#(
   parameter int unsigned W             = 16,
   parameter int unsigned CNT_W         = 5,
   parameter int unsigned MIN_HDR_BYTES = 20,
   parameter bit          FOLD_EACH     = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_sop,
   input  logic         in_eop,
   input  logic [W-1:0] in_word,
   input  logic [15:0]  in_l2_len,
   input  logic         in_local,
   output logic         out_valid,
   output logic         out_sop,
   output logic         out_eop,
   output logic [W-1:0] out_word,
   output logic         dec_valid,
   output logic [2:0]   dec_code
);
   localparam int unsigned     IDX_LEN = 1;
   localparam int unsigned     IDX_TTL = 4;
   localparam int unsigned     IDX_CKS = 5;
   localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

   generate
      if (W != 16) begin : g_chk_w
         $error("ipv4_hdr_rewrite: header word width must be 16");
      end
      if (CNT_W < 5) begin : g_chk_cnt
         $error("ipv4_hdr_rewrite: CNT_W must count up to 30 words");
      end
      if (MIN_HDR_BYTES % 4 != 0) begin : g_chk_min
         $error("ipv4_hdr_rewrite: minimum header must be whole 32-bit words");
      end
   endgenerate

   // word position within the header
   logic [CNT_W-1:0] cnt_q, idx, cnt_n;
   assign idx   = in_sop ? '0 : cnt_q;
   assign cnt_n = (idx == CNT_SAT) ? idx : idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (in_valid) cnt_q <= cnt_n;
   end

   // field capture; *_n reflects the current word as well
   hdr_fields_t fld_q, fld_n;

   always_comb begin
      fld_n = fld_q;
      if (in_sop) begin
         fld_n.ver       = in_word[15:12];
         fld_n.ihl       = in_word[11:8];
         fld_n.l2_len    = in_l2_len;
         fld_n.local_dst = in_local;
      end
      if (idx == CNT_W'(IDX_LEN)) fld_n.tot_len = in_word;
      if (idx == CNT_W'(IDX_TTL)) fld_n.ttl     = in_word[15:8];
      if (idx == CNT_W'(IDX_CKS)) fld_n.rx_cks  = in_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        fld_q <= '0;
      else if (in_valid) fld_q <= fld_n;
   end

   logic [W-1:0] sum_n;
   logic [W-1:0] patched;
   verdict_e     code_n;

   ipv4_csum_acc #(
      .W(W), .CNT_W(CNT_W), .SKIP_IDX(IDX_CKS), .FOLD_EACH(FOLD_EACH)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .start(in_sop), .valid(in_valid),
      .idx(idx), .word(in_word), .sum_o(sum_n)
   );

   ipv4_ttl_patch #(
      .W(W), .CNT_W(CNT_W), .TTL_IDX(IDX_TTL), .CKS_IDX(IDX_CKS)
   ) u_patch (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .idx(idx),
      .word(in_word), .fwd(!fld_n.local_dst), .word_o(patched)
   );

   ipv4_verdict #(
      .W(W), .CNT_W(CNT_W), .MIN_HDR_BYTES(MIN_HDR_BYTES)
   ) u_verd (
      .fld(fld_n), .cnt(cnt_n), .sum(sum_n), .code(code_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_word  <= '0;
         dec_valid <= 1'b0;
         dec_code  <= 3'd0;
      end else begin
         out_valid <= in_valid;
         out_sop   <= in_valid & in_sop;
         out_eop   <= in_valid & in_eop;
         if (in_valid) out_word <= patched;
         dec_valid <= in_valid & in_eop;
         if (in_valid & in_eop) dec_code <= code_n;
      end
   end

endmodule

// File: rtl/ipv4_hdr_rewrite_sva.sv
module ipv4_hdr_rewrite_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_sop,
   input logic        in_eop,
   input logic [15:0] in_word,
   input logic [15:0] in_l2_len,
   input logic        in_local,
   input logic        out_valid,
   input logic        out_sop,
   input logic        out_eop,
   input logic [15:0] out_word,
   input logic        dec_valid,
   input logic [2:0]  dec_code
);
   // side information of the header opened most recently
   logic        loc_q;
   logic [3:0]  ver_q;
   logic [15:0] l2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_q <= 1'b0;
         ver_q <= 4'd4;
         l2_q  <= 16'hFFFF;
      end else if (in_valid && in_sop) begin
         loc_q <= in_local;
         ver_q <= in_word[15:12];
         l2_q  <= in_l2_len;
      end
   end

   a_r1_word_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && (out_sop == $past(in_sop)) && (out_eop == $past(in_eop)));

   a_r1_first_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |=> (out_word == $past(in_word)));

   a_r2_dec_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eop) |=> dec_valid);

   a_r2_dec_only_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(in_valid && in_eop));

   a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_code <= 3'd4));

   a_r3_bad_version: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && (ver_q != 4'd4)) |-> (dec_code == 3'd4));

   a_r4_short_link: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && (l2_q < 16'd20)) |-> (dec_code == 3'd4));

   a_r8_local_not_routed: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && loc_q) |-> ((dec_code != 3'd0) && (dec_code != 3'd3)));

endmodule

bind ipv4_hdr_rewrite ipv4_hdr_rewrite_sva u_sva (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
   .in_eop(in_eop), .in_word(in_word), .in_l2_len(in_l2_len),
   .in_local(in_local), .out_valid(out_valid), .out_sop(out_sop),
   .out_eop(out_eop), .out_word(out_word), .dec_valid(dec_valid),
   .dec_code(dec_code)
);

// File: tb/sim_ipv4_hdr_rewrite.sv
module sim_ipv4_hdr_rewrite;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 150000;

   typedef logic [15:0] hdr_t [32];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_local = 1'b0;
   logic [15:0] in_word = '0, in_l2_len = '0;
   logic        out_valid, out_sop, out_eop, dec_valid;
   logic [15:0] out_word;
   logic [2:0]  dec_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   hdr_t hw;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipv4_hdr_rewrite u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_word(in_word), .in_l2_len(in_l2_len),
      .in_local(in_local), .out_valid(out_valid), .out_sop(out_sop),
      .out_eop(out_eop), .out_word(out_word), .dec_valid(dec_valid),
      .dec_code(dec_code)
   );

   function automatic logic [15:0] oc(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   function automatic logic [15:0] fsum(input hdr_t h, input int n);
      logic [15:0] s = '0;
      for (int i = 0; i < n; i++) if (i != 5) s = oc(s, h[i]);
      return s;
   endfunction

   function automatic logic [2:0] exp_code(input hdr_t h, input int n,
                                           input bit loc, input logic [15:0] l2);
      logic [3:0] ihl;
      bit bad;
      ihl = h[0][11:8];
      bad = (h[0][15:12] != 4'd4) || (l2 < 16'd20) || (ihl < 4'd5) ||
            (h[1] < {10'd0, ihl, 2'b00}) || (n != 2 * int'(ihl)) ||
            ((~fsum(h, n)) != h[5]);
      if (bad)                   return 3'd4;
      if (ihl > 4'd5)            return 3'd2;
      if (loc)                   return 3'd1;
      if (h[4][15:8] <= 8'd1)    return 3'd3;
      return 3'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // random header with valid checksum
   task automatic mk(input logic [3:0] ihl, input logic [7:0] ttl);
      for (int i = 0; i < 32; i++) hw[i] = 16'($urandom);
      hw[0] = {4'h4, ihl, 8'($urandom)};
      hw[1] = {10'd0, ihl, 2'b00} + 16'($urandom_range(0, 300));
      hw[4] = {ttl, 8'($urandom)};
      hw[5] = ~fsum(hw, 2 * int'(ihl));
   endtask

   task automatic send(input int n, input bit loc, input logic [15:0] l2, input string dtag);
      hdr_t ew;
      logic [2:0] ec;
      string tg;
      ew = hw;
      ec = exp_code(hw, n, loc, l2);
      if (!loc && n > 4 && hw[4][15:8] != 8'd0) begin
         ew[4] = {hw[4][15:8] - 8'd1, hw[4][7:0]};
         if (n > 5) begin
            if ((~fsum(hw, n)) == hw[5]) ew[5] = ~fsum(ew, n);
            else ew[5] = ~oc(oc(~hw[5], ~hw[4]), ew[4]);
         end
      end
      for (int k = 0; k <= n; k++) begin
         @(negedge clk);
         if (k > 0) begin
            tg = (k - 1 == 4 || k - 1 == 5) ? (loc ? "R8" : "R10") : "R1";
            chk(out_valid && out_word == ew[k-1] && out_sop == (k == 1) && out_eop == (k == n),
                tg, "word", {out_valid, out_sop, out_eop, 13'd0, out_word},
                {1'b1, k == 1, k == n, 13'd0, ew[k-1]});
            if (k < n) chk(!dec_valid, "R2", "early verdict", {31'd0, dec_valid}, 32'd0);
         end
         if (k < n) begin
            in_valid  = 1'b1;
            in_sop    = (k == 0);
            in_eop    = (k == n - 1);
            in_word   = hw[k];
            in_l2_len = l2;
            in_local  = loc;
         end else begin
            in_valid = 1'b0;
            in_sop   = 1'b0;
            in_eop   = 1'b0;
         end
      end
      chk(dec_valid && dec_code == ec, dtag, "verdict", {28'd0, dec_valid, dec_code},
          {28'd0, 1'b1, ec});
      @(negedge clk);
      chk(!dec_valid, "R2", "single verdict", {31'd0, dec_valid}, 32'd0);
   endtask

   // set word 9 so the sum excluding the checksum equals tgt
   task automatic force_sum(input logic [15:0] tgt);
      hw[9] = 16'd0;
      hw[9] = oc(tgt, ~fsum(hw, 10));
      hw[5] = ~fsum(hw, 10);
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      chk(!out_valid && !dec_valid, "R2", "reset outputs", {30'd0, out_valid, dec_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // worked vector, forwarded
      hw[0] = 16'h4500; hw[1] = 16'h0089; hw[2] = 16'h9713; hw[3] = 16'h0000;
      hw[4] = 16'h3e11; hw[5] = 16'h96e8; hw[6] = 16'h0a03; hw[7] = 16'h0001;
      hw[8] = 16'he000; hw[9] = 16'h6464;
      chk(~fsum(hw, 10) == 16'h96e8, "R6", "bench vector", {16'd0, ~fsum(hw, 10)}, 32'h96e8);
      send(10, 1'b0, 16'd137, "R9");
      hw[5] = 16'h96e9;                    send(10, 1'b0, 16'd137, "R6");

      mk(4'd5, 8'd64); hw[0][15:12] = 4'd6; hw[5] = ~fsum(hw, 10);
      send(10, 1'b0, 16'd60, "R3");
      mk(4'd5, 8'd64);                     send(10, 1'b0, 16'd19, "R4");
      mk(4'd5, 8'd64);                     send(10, 1'b0, 16'd20, "R9");
      mk(4'd4, 8'd64);                     send(8, 1'b0, 16'd60, "R5");
      mk(4'd5, 8'd64); hw[1] = 16'd19; hw[5] = ~fsum(hw, 10);
      send(10, 1'b0, 16'd60, "R5");
      mk(4'd5, 8'd64);                     send(9, 1'b0, 16'd60, "R5");
      mk(4'd6, 8'd1);                      send(12, 1'b0, 16'd60, "R7");
      mk(4'd6, 8'd1);                      send(12, 1'b1, 16'd60, "R7");
      mk(4'd6, 8'd9); hw[5] ^= 16'h0004;   send(12, 1'b0, 16'd60, "R11");
      mk(4'd5, 8'd0);                      send(10, 1'b1, 16'd60, "R8");
      mk(4'd5, 8'd1);                      send(10, 1'b0, 16'd60, "R9");
      mk(4'd5, 8'd2);                      send(10, 1'b0, 16'd60, "R9");
      mk(4'd5, 8'd0);                      send(10, 1'b0, 16'd60, "R10");
      mk(4'd5, 8'd64); force_sum(16'h0100);
      chk(hw[5] == 16'hfeff, "R10", "corner setup", {16'd0, hw[5]}, 32'hfeff);
      send(10, 1'b0, 16'd60, "R10");
      mk(4'd5, 8'd64); force_sum(16'hffff);
      chk(hw[5] == 16'h0000, "R10", "corner setup", {16'd0, hw[5]}, 32'h0);
      send(10, 1'b0, 16'd60, "R10");
      mk(4'd5, 8'd64); hw[0][15:12] = 4'd5; hw[5] = ~fsum(hw, 10);
      send(10, 1'b1, 16'd60, "R11");

      for (int p = 0; p < 300; p++) begin
         logic [3:0]  ihl;
         logic [7:0]  ttl;
         logic [15:0] l2;
         bit          loc;
         int          n;
         int          fault;
         ihl = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(6, 15)) : 4'd5;
         case ($urandom_range(0, 3))
            0:       ttl = 8'd0;
            1:       ttl = 8'd1;
            2:       ttl = 8'd2;
            default: ttl = 8'($urandom);
         endcase
         loc = $urandom_range(0, 3) == 0;
         mk(ihl, ttl);
         n  = 2 * int'(ihl);
         l2 = {10'd0, ihl, 2'b00} + 16'($urandom_range(0, 200));
         fault = $urandom_range(0, 9);
         case (fault)
            0: hw[5] ^= 16'(1 << $urandom_range(0, 15));
            1: begin hw[0][15:12] = 4'($urandom_range(5, 15)); hw[5] = ~fsum(hw, n); end
            2: l2 = 16'($urandom_range(0, 19));
            3: begin hw[1] = 16'($urandom_range(0, 4 * int'(ihl) - 1)); hw[5] = ~fsum(hw, n); end
            4: n = n - 1;
            default: ;
         endcase
         send(n, loc, l2, "R11");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule